// File: doc/BRIEF.md
# Dual Parallel Port with Transfer Strobe

This block is a small bus-mapped peripheral with two 8-bit general-purpose ports, A and B. Each port has an output value register and a direction register. Each direction bit chooses whether its pin is driven from the value register or left as an input. Reading a port value offset always returns the pin levels seen at that moment, so software can check what is actually on the wire, even for pins it drives itself.

Any read or write of port B starts a short countdown. When the countdown ends, an active-low strobe pulses for one clock. A remote device can treat the pulse as "data ready" or "data accepted". For a 16-bit word, software touches port A first and port B last, so the pulse marks the whole word as complete.

A separate active-low flag input is synchronized and watched for falling edges. Each falling edge latches an interrupt status bit, and software reads that bit at a status offset. The two highest pins of port B can be handed to timer outputs through per-pin override enables.

Top module: `pio_hshk`

## Requirements
- R1: A write with `cs` and `wr` high stores `wdata` at offset 2 (port A direction) or 3 (port B direction). Reading those offsets returns the stored value. Writes to offsets 0 and 1 store the port A and port B output values.
- R2: Each `pa_oe`/`pb_oe` bit equals the matching direction bit (1 = driven, 0 = input). Each `pa_out`/`pb_out` bit equals the stored output value bit. Both take effect in the cycle after the write edge.
- R3: A read at offset 0 or 1 returns the pin inputs `pa_in`/`pb_in` as sampled at the read edge, whatever the direction bits hold.
- R4: A port B access (`cs` with `rd` or `wr`, offset 1) sampled at clock edge k drives `hs_n` low from edge k+3 to edge k+4: exactly one cycle. At all other times `hs_n` is high.
- R5: A new port B access restarts the countdown. If it arrives at the edge where the pending pulse would fire, that pulse is cancelled and only the new one follows, three edges later.
- R6: `flag_n` passes through two synchronizing flops. A high-to-low change first sampled at edge e sets `irq` at edge e+2. A low-to-high change never sets it.
- R7: A read at offset 4 returns `irq` in bit 0, with all other bits 0, and clears the bit. If a falling edge sets the bit at the same edge, the set wins and the bit stays 1.
- R8: When `tmr_en[j]` is 1, pin 6+j of port B is forced to output mode (`pb_oe`=1) and drives `tmr_val[j]`. When `tmr_en[j]` is 0, that pin follows its direction and value registers. Reads of offset 1 still return `pb_in`.
- R9: After reset: both direction registers are 0, both value registers are 0, `hs_n` is 1, `irq` is 0 and `rdata` is 0.
- R10: `rdata` is registered and appears one cycle after the read edge. Offsets 5 to 7 read as 0. Without a read, `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| tmr_en | input | 2 | Override enables for port B pins 6 and 7 |
| tmr_val | input | 2 | Override drive values for port B pins 6 and 7 |
| hs_n | output | 1 | Active-low transfer strobe |
| flag_n | input | 1 | Active-low flag input, falling-edge sensitive |
| irq | output | 1 | Flag interrupt status |

## Verification
The status bit can be cleared by a read at offset 4 in the same cycle that a synchronized falling edge sets it. The bench starts a flag fall and then moves the status read across edges 0 to 5 after it, one position per pass. Each pass predicts the read value and the final `irq` from which side of the set edge the read lands on. The same kind of collision arises in the strobe when a second port B access coincides with the firing edge. A sweep of the gap between two accesses checks, cycle by cycle, which pulses appear.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  localparam int PIO_AW = 3;

  typedef enum logic [PIO_AW-1:0] {
    OFS_PA_VAL = 3'd0,
    OFS_PB_VAL = 3'd1,
    OFS_PA_DIR = 3'd2,
    OFS_PB_DIR = 3'd3,
    OFS_STATUS = 3'd4
  } pio_ofs_e;
endpackage

// File: rtl/pio_port.sv
`timescale 1ns/1ps
module pio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_val,
  input  logic         we_dir,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] val_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      dir_q <= '0;
    end else begin
      if (we_val) val_q <= wdata;
      if (we_dir) dir_q <= wdata;
    end
  end

  // R1: a direction write is visible on the next cycle
  p_dir_write_r1: assert property (@(posedge clk) disable iff (rst)
    we_dir |=> dir_q == $past(wdata));
  p_val_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !we_val |=> $stable(val_q));
endmodule

// File: rtl/pio_strobe.sv
`timescale 1ns/1ps
module pio_strobe #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic hs_n
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      hs_n <= 1'b1;
    end else begin
      hs_n <= 1'b1;
      if (trig) begin
        cnt <= CW'(DELAY);
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) hs_n <= 1'b0;
      end
    end
  end

  p_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    !hs_n |=> hs_n);
  p_fire_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(1) && !trig) |=> !hs_n);
  // R5: an access on the firing edge suppresses the pulse
  p_retrig_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    trig |=> hs_n);
endmodule

// File: rtl/pio_flag.sv
`timescale 1ns/1ps
module pio_flag #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flag_n,
  input  logic clr,
  output logic flag_q
);
  logic [SYNC_LEN-1:0] sy;
  logic                prev;
  logic                fall;

  assign fall = prev & ~sy[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sy     <= '1;
      prev   <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sy   <= {sy[SYNC_LEN-2:0], flag_n};
      prev <= sy[SYNC_LEN-1];
      if (fall)     flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  p_set_r6: assert property (@(posedge clk) disable iff (rst)
    fall |=> flag_q);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && !fall) |=> !flag_q);
endmodule

// File: rtl/pio_hshk.sv
`timescale 1ns/1ps
module pio_hshk
  import pio_pkg::*;
#(
  parameter int W        = 8,
  parameter int HS_DELAY = 3,
  parameter int SYNC_LEN = 2,
  parameter int NTMR     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [PIO_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pa_in,
  output logic [W-1:0]      pa_out,
  output logic [W-1:0]      pa_oe,
  input  logic [W-1:0]      pb_in,
  output logic [W-1:0]      pb_out,
  output logic [W-1:0]      pb_oe,
  input  logic [NTMR-1:0]   tmr_en,
  input  logic [NTMR-1:0]   tmr_val,
  output logic              hs_n,
  input  logic              flag_n,
  output logic              irq
);
  localparam int OVR_LO = W - NTMR;

  logic          rd_en, wr_en, pb_touch, st_rd;
  logic [W-1:0]  pa_val, pa_dir, pb_val, pb_dir;

  assign rd_en    = cs & rd;
  assign wr_en    = cs & wr;
  assign pb_touch = cs & (rd | wr) & (addr == OFS_PB_VAL);
  assign st_rd    = rd_en & (addr == OFS_STATUS);

  pio_port #(.W(W)) u_port_a (
    .clk(clk), .rst(rst),
    .we_val(wr_en && addr == OFS_PA_VAL),
    .we_dir(wr_en && addr == OFS_PA_DIR),
    .wdata(wdata), .val_q(pa_val), .dir_q(pa_dir)
  );

  pio_port #(.W(W)) u_port_b (
    .clk(clk), .rst(rst),
    .we_val(wr_en && addr == OFS_PB_VAL),
    .we_dir(wr_en && addr == OFS_PB_DIR),
    .wdata(wdata), .val_q(pb_val), .dir_q(pb_dir)
  );

  pio_strobe #(.DELAY(HS_DELAY)) u_strobe (
    .clk(clk), .rst(rst), .trig(pb_touch), .hs_n(hs_n)
  );

  pio_flag #(.SYNC_LEN(SYNC_LEN)) u_flag (
    .clk(clk), .rst(rst), .flag_n(flag_n), .clr(st_rd), .flag_q(irq)
  );

  assign pa_out = pa_val;
  assign pa_oe  = pa_dir;

  for (genvar i = 0; i < W; i++) begin : g_pb_pin
    if (i >= OVR_LO) begin : g_ovr
      assign pb_out[i] = tmr_en[i-OVR_LO] ? tmr_val[i-OVR_LO] : pb_val[i];
      assign pb_oe[i]  = tmr_en[i-OVR_LO] | pb_dir[i];
      // R8: override forces drive of the timer value
      p_ovr_r8: assert property (@(posedge clk) disable iff (rst)
        tmr_en[i-OVR_LO] |-> (pb_oe[i] && pb_out[i] == tmr_val[i-OVR_LO]));
    end else begin : g_plain
      assign pb_out[i] = pb_val[i];
      assign pb_oe[i]  = pb_dir[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        OFS_PA_VAL: rdata <= pa_in;
        OFS_PB_VAL: rdata <= pb_in;
        OFS_PA_DIR: rdata <= pa_dir;
        OFS_PB_DIR: rdata <= pb_dir;
        OFS_STATUS: rdata <= W'(irq);
        default:    rdata <= '0;
      endcase
    end
  end

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  p_pin_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_PA_VAL) |=> rdata == $past(pa_in));
  p_status_read_r7: assert property (@(posedge clk) disable iff (rst)
    st_rd |=> rdata == W'($past(irq)));
endmodule

// File: tb/test_pio_hshk.sv
`timescale 1ns/1ps
module test_pio_hshk;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pa_in = '0, pa_out, pa_oe;
  logic [7:0] pb_in = '0, pb_out, pb_oe;
  logic [1:0] tmr_en = '0, tmr_val = '0;
  logic       hs_n, flag_n = 1'b1, irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pio_hshk i_pio_hshk (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .tmr_en(tmr_en), .tmr_val(tmr_val), .hs_n(hs_n), .flag_n(flag_n),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); d = rdata; cs = 0; rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9: reset state
    chk(hs_n == 1'b1, "R9 hs_n", hs_n, 1);
    chk(pa_oe == 0 && pb_oe == 0, "R9 oe", {pa_oe, pb_oe}, 0);
    chk(pa_out == 0 && pb_out == 0, "R9 out", {pa_out, pb_out}, 0);
    chk(irq == 0, "R9 irq", irq, 0);
    chk(rdata == 0, "R9 rdata", rdata, 0);

    // R1 R2 R3: full sweep of direction values on both ports
    for (int v = 0; v < 256; v++) begin
      bus_wr(3'd2, v[7:0]);
      bus_wr(3'd0, ~v[7:0]);
      chk(pa_oe == v[7:0], "R2 pa_oe", pa_oe, v);
      chk(pa_out == ~v[7:0], "R2 pa_out", pa_out, ~v[7:0]);
      pa_in = v[7:0] ^ 8'hA5;
      bus_rd(3'd0, r);
      chk(r == (v[7:0] ^ 8'hA5), "R3 port A pins", r, v[7:0] ^ 8'hA5);
      bus_rd(3'd2, r);
      chk(r == v[7:0], "R1 port A dir readback", r, v);
      bus_wr(3'd3, ~v[7:0]);
      bus_wr(3'd1, v[7:0]);
      chk(pb_oe == ~v[7:0], "R2 pb_oe", pb_oe, ~v[7:0]);
      chk(pb_out == v[7:0], "R2 pb_out", pb_out, v);
      pb_in = v[7:0] ^ 8'h3C;
      bus_rd(3'd1, r);
      chk(r == (v[7:0] ^ 8'h3C), "R3 port B pins", r, v[7:0] ^ 8'h3C);
      bus_rd(3'd3, r);
      chk(r == ~v[7:0], "R1 port B dir readback", r, ~v[7:0]);
    end

    // R8: override of pins 6 and 7
    bus_wr(3'd3, 8'h0F);
    bus_wr(3'd1, 8'hC3);
    pb_in = 8'h5A;
    for (int ov = 0; ov < 4; ov++) begin
      for (int tv = 0; tv < 4; tv++) begin
        logic [7:0] eo, ed;
        @(negedge clk); tmr_en = ov[1:0]; tmr_val = tv[1:0];
        @(negedge clk);
        ed = {ov[1] | 1'b0, ov[0] | 1'b0, 6'h0F};
        eo = {ov[1] ? tv[1] : 1'b1, ov[0] ? tv[0] : 1'b1, 6'h03};
        chk(pb_oe == ed, "R8 oe", pb_oe, ed);
        chk(pb_out == eo, "R8 out", pb_out, eo);
        bus_rd(3'd1, r);
        chk(r == 8'h5A, "R8 pin read", r, 8'h5A);
      end
    end
    tmr_en = 0;

    // R10: unmapped offsets and hold
    for (int a = 5; a < 8; a++) begin
      bus_rd(a[2:0], r);
      chk(r == 0, "R10 unmapped", r, 0);
    end
    pa_in = 8'h77;
    bus_rd(3'd0, r);
    repeat (2) @(negedge clk);
    chk(rdata == 8'h77, "R10 hold", rdata, 8'h77);

    // R4 R5: sweep the gap between two port B accesses
    for (int g = 1; g <= 6; g++) begin
      repeat (6) @(negedge clk);
      for (int i = 0; i <= g + 7; i++) begin
        bit exp_low;
        @(negedge clk);
        exp_low = (i == g + 4) || (g >= 4 && i == 4);
        if (g <= 3) chk(hs_n == !exp_low, "R5 retrigger", hs_n, !exp_low);
        else        chk(hs_n == !exp_low, "R4 strobe", hs_n, !exp_low);
        if (i == 0 || i == g) begin cs = 1; rd = 1; addr = 3'd1; end
        else begin cs = 0; rd = 0; end
      end
    end
    // R4: no access with chip select low
    @(negedge clk); rd = 1; addr = 3'd1;
    repeat (6) begin
      @(negedge clk);
      chk(hs_n == 1, "R4 cs low", hs_n, 1);
    end
    rd = 0;

    // R6 R7: move the status read across the set edge
    for (int d = 0; d <= 5; d++) begin
      logic cap;
      flag_n = 1;
      repeat (5) @(negedge clk);
      bus_rd(3'd4, r);
      @(negedge clk);
      chk(irq == 0, "R7 clear", irq, 0);
      cap = 0;
      for (int i = 0; i <= 8; i++) begin
        @(negedge clk);
        if (i == 2) chk(irq == 0, "R6 sync delay", irq, 0);
        if (i == 3) chk(irq == 1, "R6 set", irq, 1);
        if (i == d + 1) cap = rdata[0];
        if (i == 0) flag_n = 0;
        if (i == d) begin cs = 1; rd = 1; addr = 3'd4; end
        else begin cs = 0; rd = 0; end
      end
      chk(irq == (d <= 2), "R7 set wins / clear", irq, (d <= 2));
      chk(cap == (d > 2), "R7 read value", cap, (d > 2));
    end
    // R6: rising edge never sets
    bus_rd(3'd4, r);
    @(negedge clk); flag_n = 1;
    repeat (6) @(negedge clk);
    chk(irq == 0, "R6 rising ignored", irq, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule